// File: doc/BRIEF.md
# DRAM Impedance Calibration Controller

This block sets the drive and termination impedance of the DRAM I/O pads. A host programs a single 32-bit control word. Depending on its contents, the controller does one of two things. It can ask an external analog calibration engine to calibrate against a precision resistor, using two 4-bit divisors: one for termination and one for output drive. It can also skip calibration altogether and apply a 20-bit preset impedance code taken straight from the word.

The host polls a status register for completion and reads back the resulting code. The same small register bank also holds a 2-bit termination enable. That enable drives the DQ and DQS on-die-termination controls independently, and it reads back duplicated at both ends of the I/O control word.

The analog engine is reached over a level request and a one-cycle acknowledge that returns a result code. The engine itself is outside the block.

Top module: `zq_imp_ctrl`

## Requirements
- R1: After reset, status reads 0, the result register reads 0, `imp_code` is 0, `cal_req` is low and both termination enables are low.
- R2: A CTRL write (address 0) with bit 31 set starts a calibration run when bits 27:8 are zero and bit 28 is clear. From the next cycle, `cal_req` is high, `cal_term_div` equals bits 3:0 and `cal_out_div` equals bits 7:4. All three hold until `cal_ack`.
- R3: On the cycle `cal_ack` is sampled high, `cal_result` is captured. From the next cycle, `imp_code` and the result register hold that value, `cal_req` is low and the done flag is set.
- R4: A started run whose bits 27:8 are nonzero never raises `cal_req`. From the next cycle, `imp_code` equals bits 27:8.
- R5: Bit 28 set in a started run forces the preset path even when bits 27:8 are zero. In that case `imp_code` becomes 0.
- R6: On the preset path, the done flag is set one cycle after the preset code is applied, which is two cycles after the write.
- R7: An accepted start clears the done flag from the next cycle.
- R8: A start write while a run is in progress is ignored. The divisors, `imp_code` and the final result remain those of the run already under way.
- R9: A CTRL write with bit 31 clear starts nothing. CTRL reads return the written bits 30:0 with bit 31 reading 0.
- R10: An IOCTL write (address 2) sets `odt_dq_en` from bit 0 and `odt_dqs_en` from bit 1. IOCTL reads show these two bits at both 1:0 and 31:30, and the outputs change only on such a write.
- R11: The result register (address 3) reads the code zero-extended while done is set, and 0 otherwise.
- R12: Status (address 1) reads done at bit 31 and busy at bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cal_req | output | 1 | Calibration request to the analog engine |
| cal_term_div | output | 4 | Termination divisor sent with the request |
| cal_out_div | output | 4 | Output-drive divisor sent with the request |
| cal_ack | input | 1 | One-cycle completion pulse from the engine |
| cal_result | input | 20 | Code returned by the engine with `cal_ack` |
| odt_dq_en | output | 1 | On-die termination enable for DQ |
| odt_dqs_en | output | 1 | On-die termination enable for DQS |
| imp_code | output | 20 | Impedance code applied to the pads |

## Verification
Some properties are checked on every cycle:
- the request and its divisors stay stable until acknowledge;
- the captured code matches the acknowledged result;
- done follows the preset step by exactly one cycle;
- an accepted start clears done;
- an ignored start leaves the divisors untouched;
- the termination outputs move only on an IOCTL write.

Other behaviour is only visible through the bench's scenarios:
- which path a given control word selects, including the bit 28 override with zero data;
- the readback formats;
- the end result of a run that received a stray second start;
- randomly mixed words and engine latencies.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

  localparam int DATA_W         = 32;
  localparam int DIV_W          = 4;
  localparam int CODE_W         = 20;
  localparam int PRESET_LO      = 2 * DIV_W;
  localparam int PRESET_HI      = PRESET_LO + CODE_W - 1;
  localparam int PRESET_SEL_BIT = PRESET_HI + 1;
  localparam int START_BIT      = DATA_W - 1;
  localparam int DONE_BIT       = DATA_W - 1;
  localparam int ODT_W          = 2;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_IOCTL = 2'd2,
    ADDR_CODE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_CAL_WAIT   = 2'd1,
    ST_PRESET_FIN = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              preset_mode;
    logic [DIV_W-1:0]  out_div;
    logic [DIV_W-1:0]  term_div;
    logic [CODE_W-1:0] preset_code;
  } zq_cmd_t;

  // Split the low part of a control word into the command fields
  function automatic zq_cmd_t decode_param(logic [PRESET_SEL_BIT:0] w);
    zq_cmd_t c;
    c.term_div    = w[DIV_W-1:0];
    c.out_div     = w[2*DIV_W-1:DIV_W];
    c.preset_code = w[PRESET_HI:PRESET_LO];
    c.preset_mode = w[PRESET_SEL_BIT] | (|w[PRESET_HI:PRESET_LO]);
    return c;
  endfunction

  // Termination enable duplicated at the bottom and top of the word
  function automatic logic [DATA_W-1:0] io_word(logic [ODT_W-1:0] odt);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ODT_W-1:0] = odt;
    w[DATA_W-1 -: ODT_W] = odt;
    return w;
  endfunction

endpackage

// File: rtl/zq_param_decode.sv
module zq_param_decode
  import zq_cal_pkg::*;
(
  input  logic [PRESET_SEL_BIT:0] param_word,
  output zq_cmd_t                 cmd
);

  always_comb cmd = decode_param(param_word);

endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
  import zq_cal_pkg::*;
#(
  parameter int P_DIV_W  = DIV_W,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  zq_cmd_t             cmd,
  input  logic                cal_ack,
  input  logic [P_CODE_W-1:0] cal_result,
  output logic                cal_req,
  output logic [P_DIV_W-1:0]  cal_term_div,
  output logic [P_DIV_W-1:0]  cal_out_div,
  output logic [P_CODE_W-1:0] code,
  output logic                done,
  output logic                busy
);

  seq_state_e state;
  logic       start_taken;
  logic       start_ignored;

  assign busy          = (state != ST_IDLE);
  assign start_taken   = start_req && !busy;
  assign start_ignored = start_req && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cal_req      <= 1'b0;
      cal_term_div <= '0;
      cal_out_div  <= '0;
      code         <= '0;
      done         <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            done <= 1'b0;
            if (cmd.preset_mode) begin
              code  <= cmd.preset_code;
              state <= ST_PRESET_FIN;
            end else begin
              cal_term_div <= cmd.term_div;
              cal_out_div  <= cmd.out_div;
              cal_req      <= 1'b1;
              state        <= ST_CAL_WAIT;
            end
          end
        end
        ST_CAL_WAIT: begin
          if (cal_ack) begin
            code    <= cal_result;
            cal_req <= 1'b0;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_PRESET_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !cal_ack) |=> (cal_req && $stable(cal_term_div) && $stable(cal_out_div)));

  assert_ack_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && cal_ack) |=> (done && !cal_req && code == $past(cal_result)));

  assert_preset_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_taken && cmd.preset_mode) |=> !cal_req);

  assert_preset_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRESET_FIN) |=> (done && !busy && $stable(code)));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken |=> !done);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ignored |=> ($stable(cal_term_div) && $stable(cal_out_div)));

endmodule

// File: rtl/zq_odt_ctl.sv
module zq_odt_ctl
  import zq_cal_pkg::*;
#(
  parameter int P_ODT_W = ODT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [P_ODT_W-1:0] wdata,
  output logic [P_ODT_W-1:0] odt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odt <= '0;
    else if (wr) odt <= wdata;
  end

  assert_odt_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(odt));

endmodule

// File: rtl/zq_imp_ctrl.sv
module zq_imp_ctrl
  import zq_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cal_req,
  output logic [DIV_W-1:0]  cal_term_div,
  output logic [DIV_W-1:0]  cal_out_div,
  input  logic              cal_ack,
  input  logic [CODE_W-1:0] cal_result,
  output logic              odt_dq_en,
  output logic              odt_dqs_en,
  output logic [CODE_W-1:0] imp_code
);

  reg_addr_e         addr_q;
  logic [DATA_W-2:0] cfg_q;
  logic              ctrl_wr;
  logic              ioctl_wr;
  logic              start_req;
  zq_cmd_t           cmd;
  logic              done;
  logic              busy;
  logic [ODT_W-1:0]  odt;

  assign addr_q    = reg_addr_e'(reg_addr);
  assign ctrl_wr   = reg_wr && (addr_q == ADDR_CTRL);
  assign ioctl_wr  = reg_wr && (addr_q == ADDR_IOCTL);
  assign start_req = ctrl_wr && reg_wdata[START_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (ctrl_wr) cfg_q <= reg_wdata[DATA_W-2:0];
  end

  zq_param_decode u_decode (
    .param_word (reg_wdata[PRESET_SEL_BIT:0]),
    .cmd        (cmd)
  );

  zq_cal_seq #(.P_DIV_W(DIV_W), .P_CODE_W(CODE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .cmd          (cmd),
    .cal_ack      (cal_ack),
    .cal_result   (cal_result),
    .cal_req      (cal_req),
    .cal_term_div (cal_term_div),
    .cal_out_div  (cal_out_div),
    .code         (imp_code),
    .done         (done),
    .busy         (busy)
  );

  zq_odt_ctl #(.P_ODT_W(ODT_W)) u_odt (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ioctl_wr),
    .wdata (reg_wdata[ODT_W-1:0]),
    .odt   (odt)
  );

  assign odt_dq_en  = odt[0];
  assign odt_dqs_en = odt[1];

  always_comb begin
    reg_rdata = '0;
    unique case (addr_q)
      ADDR_CTRL:  reg_rdata = {1'b0, cfg_q};
      ADDR_STAT: begin
        reg_rdata[DONE_BIT] = done;
        reg_rdata[0]        = busy;
      end
      ADDR_IOCTL: reg_rdata = io_word(odt);
      ADDR_CODE:  reg_rdata = done ? DATA_W'(imp_code) : '0;
      default:    reg_rdata = '0;
    endcase
  end

  assert_code_hidden_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == ADDR_CODE && !done) |-> (reg_rdata == '0));

endmodule

// File: tb/test_zq_imp_ctrl.sv
module test_zq_imp_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cal_req;
  logic [3:0]  cal_term_div;
  logic [3:0]  cal_out_div;
  logic        cal_ack;
  logic [19:0] cal_result;
  logic        odt_dq_en;
  logic        odt_dqs_en;
  logic [19:0] imp_code;

  int n_cmp = 0;
  int n_bad = 0;
  int stub_delay = 2;
  int stub_cnt;
  bit finished = 0;

  always #10 clk = ~clk;

  zq_imp_ctrl i_zq_imp_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .cal_req (cal_req),
    .cal_term_div (cal_term_div), .cal_out_div (cal_out_div),
    .cal_ack (cal_ack), .cal_result (cal_result), .odt_dq_en (odt_dq_en),
    .odt_dqs_en (odt_dqs_en), .imp_code (imp_code)
  );

  function automatic logic [19:0] engine_code(logic [3:0] t, logic [3:0] o);
    return {o, t, (12'({o, t}) * 12'd37) ^ 12'h5A3};
  endfunction

  function automatic bit uses_preset(logic [31:0] w);
    return w[28] || (w[27:8] != 20'd0);
  endfunction

  // analog engine stand-in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_ack <= 1'b0; cal_result <= '0; stub_cnt <= 0;
    end else if (cal_req && !cal_ack) begin
      if (stub_cnt >= stub_delay) begin
        cal_ack <= 1'b1;
        cal_result <= engine_code(cal_term_div, cal_out_div);
        stub_cnt <= 0;
      end else stub_cnt <= stub_cnt + 1;
    end else begin
      cal_ack <= 1'b0; stub_cnt <= 0;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd_reg(2'd1, s);
      if (s[31]) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    logic [19:0] exp_code;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd1, d); check("R1 status", d, 32'h0);
    rd_reg(2'd3, d); check("R1 code reg", d, 32'h0);
    check("R1 imp_code", 32'(imp_code), 32'h0);
    check("R1 cal_req", 32'(cal_req), 32'h0);
    check("R1 odt", {30'd0, odt_dqs_en, odt_dq_en}, 32'h0);

    // R2 / R12 / R11 / R3 calibration run
    stub_delay = 3;
    wr_reg(2'd0, 32'h8000_003B);
    check("R2 cal_req", 32'(cal_req), 32'h1);
    check("R2 term div", 32'(cal_term_div), 32'hB);
    check("R2 out div", 32'(cal_out_div), 32'h3);
    rd_reg(2'd1, d); check("R12 busy status", d, 32'h0000_0001);
    rd_reg(2'd3, d); check("R11 code hidden", d, 32'h0);
    wait_done();
    check("R3 imp_code", 32'(imp_code), 32'(engine_code(4'hB, 4'h3)));
    check("R3 cal_req low", 32'(cal_req), 32'h0);
    rd_reg(2'd3, d); check("R11 code visible", d, 32'(engine_code(4'hB, 4'h3)));
    rd_reg(2'd1, d); check("R12 done status", d, 32'h8000_0000);

    // R9 write without start
    wr_reg(2'd0, 32'h0000_0057);
    check("R9 no req", 32'(cal_req), 32'h0);
    rd_reg(2'd1, d); check("R9 status kept", d, 32'h8000_0000);
    rd_reg(2'd0, d); check("R9 ctrl readback", d, 32'h0000_0057);
    wr_reg(2'd0, 32'hF000_0001);
    rd_reg(2'd0, d); check("R9 bit31 reads 0", d, 32'h7000_0001);
    wait_done();

    // R7 start clears done
    wr_reg(2'd0, 32'h8000_0021);
    rd_reg(2'd1, d); check("R7 done cleared", d, 32'h0000_0001);
    wait_done();

    // R4 / R6 preset data
    wr_reg(2'd0, 32'h8123_4500);
    check("R4 no req", 32'(cal_req), 32'h0);
    check("R4 imp_code", 32'(imp_code), 32'h12345);
    rd_reg(2'd1, d); check("R6 not yet done", d, 32'h0000_0001);
    @(negedge clk);
    rd_reg(2'd1, d); check("R6 done next cycle", d, 32'h8000_0000);
    rd_reg(2'd3, d); check("R11 preset code", d, 32'h0001_2345);

    // R5 forced preset with zero data
    wr_reg(2'd0, 32'h9000_0077);
    check("R5 no req", 32'(cal_req), 32'h0);
    check("R5 imp_code zero", 32'(imp_code), 32'h0);
    @(negedge clk);
    rd_reg(2'd1, d); check("R5 done", d, 32'h8000_0000);

    // R8 start while busy ignored
    stub_delay = 20;
    wr_reg(2'd0, 32'h8000_0021);
    @(negedge clk);
    wr_reg(2'd0, 32'h8000_0099);
    check("R8 term div kept", 32'(cal_term_div), 32'h1);
    check("R8 out div kept", 32'(cal_out_div), 32'h2);
    wr_reg(2'd0, 32'h8ABC_DE00);
    check("R8 code not preset", 32'(imp_code) == 32'hABCDE ? 32'h1 : 32'h0, 32'h0);
    wait_done();
    check("R8 first run result", 32'(imp_code), 32'(engine_code(4'h1, 4'h2)));

    // R10 termination enables
    wr_reg(2'd2, 32'h0000_0001);
    check("R10 dq only", {30'd0, odt_dqs_en, odt_dq_en}, 32'h1);
    rd_reg(2'd2, d); check("R10 mirror 1", d, 32'h4000_0001);
    wr_reg(2'd2, 32'h0000_0002);
    check("R10 dqs only", {30'd0, odt_dqs_en, odt_dq_en}, 32'h2);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, d); check("R10 mirror 3", d, 32'hC000_0003);
    wr_reg(2'd0, 32'h0000_0000);
    check("R10 other write keeps", {30'd0, odt_dqs_en, odt_dq_en}, 32'h3);
    wr_reg(2'd2, 32'h0);
    check("R10 cleared", {30'd0, odt_dqs_en, odt_dq_en}, 32'h0);

    // random mix, R2 R3 R4
    for (int k = 0; k < 40; k++) begin
      w = $urandom;
      stub_delay = int'($urandom % 8);
      if ($urandom % 2 == 0) w = w & 32'h0000_00FF;
      w[31] = 1'b1;
      exp_code = uses_preset(w) ? w[27:8] : engine_code(w[3:0], w[7:4]);
      wr_reg(2'd0, w);
      if (!uses_preset(w)) check("R2 random req", 32'(cal_req), 32'h1);
      else check("R4 random no req", 32'(cal_req), 32'h0);
      wait_done();
      check(uses_preset(w) ? "R4 random code" : "R3 random code",
            32'(imp_code), 32'(exp_code));
    end

    finish_run();
  end

endmodule